// File: doc/BRIEF.md
# Next Program Counter Unit

This block holds the program counter of a processor with fixed 32-bit instructions and works out the fetch address for the next cycle. Every clock edge it loads one of four candidates: the sequential address (current PC plus 4), a PC-relative branch target, a region-local jump target built from a 26-bit word index, or a full address taken from a register.

The decode stage supplies the 16-bit and 26-bit immediate fields of the current instruction, one-bit controls for branch-if-equal, branch-if-not-equal, jump and jump-through-register, the two register values a branch compares, and the register value used as an indirect target. Branches are not delayed: a taken branch or jump changes the address presented in the very next cycle. The fetch side reads the current PC from the single output port.

Top module: `npc_unit`

## Requirements
- R1: While `rst_n` is low the PC is 0x00000000. Reset is asynchronous on assertion, and the first update happens on the first rising clock edge after release.
- R2: With none of `br_eq_i`, `br_ne_i`, `jmp_i`, `jreg_i` high, each rising edge loads PC + 4.
- R3: When `br_eq_i` is high and `cmp_a_i` equals `cmp_b_i`, the next PC is PC + 4 + {14 copies of `imm16_i[15]`, `imm16_i`, 2'b00}, so negative immediates branch backwards.
- R4: When `br_eq_i` is high and the compared values differ, the next PC is PC + 4.
- R5: When `br_ne_i` is high the branch is taken (same target as R3) if the compared values differ, and the PC moves to PC + 4 if they are equal.
- R6: When `jmp_i` is high the next PC is {bits [31:28] of PC + 4, `jidx_i`, 2'b00}.
- R7: When `jreg_i` is high the next PC is `jreg_tgt_i` as given, all 32 bits.
- R8: Priority among simultaneous controls is `jreg_i` first, then `jmp_i`, then the branch controls.
- R9: A redirect takes effect on the first edge: the PC after the edge at which a taken control is sampled is the target, with no slot instruction in between.
- R10: Address arithmetic wraps modulo 2^32 (0xFFFFFFFC + 4 = 0), and a jump issued from the last word of a 256 MB region lands in the following region.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low reset, asynchronous assertion |
| imm16_i | input | 16 | Branch word offset, two's complement |
| jidx_i | input | 26 | Jump word index |
| br_eq_i | input | 1 | Branch when compared values are equal |
| br_ne_i | input | 1 | Branch when compared values differ |
| jmp_i | input | 1 | Region-local jump |
| jreg_i | input | 1 | Jump to register value |
| cmp_a_i | input | 32 | First compared register value |
| cmp_b_i | input | 32 | Second compared register value |
| jreg_tgt_i | input | 32 | Indirect jump target |
| pc_o | output | 32 | Current program counter |

## Verification
On every cycle, the assertions check the step from one PC to the next for each kind of control: the sequential increment, taken and untaken equal-branches, the region splice of a jump, and the indirect load when the register jump wins priority. The reset value, the wrap at the top of the address space, a jump that crosses a region boundary and combinations of several controls at once are shown only by the bench's directed scenarios, which compare each new PC with a value worked out from the requirements.

// File: rtl/npc_pkg.sv
package npc_pkg;

  typedef enum logic [1:0] {
    NPC_SEQ    = 2'd0,
    NPC_BRANCH = 2'd1,
    NPC_JUMP   = 2'd2,
    NPC_JREG   = 2'd3
  } npc_src_e;

  localparam int unsigned NPC_INSN_BYTES = 4;

endpackage

// File: rtl/npc_targets.sv
module npc_targets #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned IMM_W  = 16,
  parameter int unsigned JIDX_W = 26
) (
  input  logic [ADDR_W-1:0] pc_i,
  input  logic [IMM_W-1:0]  imm_i,
  input  logic [JIDX_W-1:0] jidx_i,
  output logic [ADDR_W-1:0] seq_o,
  output logic [ADDR_W-1:0] br_o,
  output logic [ADDR_W-1:0] jmp_o
);
  import npc_pkg::*;

  localparam int unsigned SEXT_W  = ADDR_W - IMM_W - 2;
  localparam int unsigned REGION_W = ADDR_W - JIDX_W - 2;
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(NPC_INSN_BYTES);

  logic [ADDR_W-1:0] byte_off;

  always_comb begin
    seq_o    = pc_i + STEP;
    byte_off = {{SEXT_W{imm_i[IMM_W-1]}}, imm_i, 2'b00};
    br_o     = seq_o + byte_off;
    jmp_o    = {seq_o[ADDR_W-1 -: REGION_W], jidx_i, 2'b00};
  end

endmodule

// File: rtl/npc_branch_cond.sv
module npc_branch_cond #(
  parameter int unsigned DATA_W = 32
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic              on_eq_i,
  input  logic              on_ne_i,
  output logic              take_o
);
  logic same;

  always_comb begin
    same   = (a_i == b_i);
    take_o = (on_eq_i & same) | (on_ne_i & ~same);
  end

endmodule

// File: rtl/npc_select.sv
module npc_select #(
  parameter int unsigned ADDR_W = 32
) (
  input  logic              jreg_i,
  input  logic              jmp_i,
  input  logic              take_i,
  input  logic [ADDR_W-1:0] seq_i,
  input  logic [ADDR_W-1:0] br_i,
  input  logic [ADDR_W-1:0] jmp_tgt_i,
  input  logic [ADDR_W-1:0] reg_tgt_i,
  output logic [ADDR_W-1:0] next_o
);
  import npc_pkg::*;

  npc_src_e src;

  always_comb begin
    if (jreg_i)      src = NPC_JREG;
    else if (jmp_i)  src = NPC_JUMP;
    else if (take_i) src = NPC_BRANCH;
    else             src = NPC_SEQ;
  end

  always_comb begin
    unique case (src)
      NPC_JREG:   next_o = reg_tgt_i;
      NPC_JUMP:   next_o = jmp_tgt_i;
      NPC_BRANCH: next_o = br_i;
      default:    next_o = seq_i;
    endcase
  end

endmodule

// File: rtl/npc_unit.sv
module npc_unit #(
  parameter int unsigned ADDR_W   = 32,
  parameter int unsigned IMM_W    = 16,
  parameter int unsigned JIDX_W   = 26,
  parameter logic [ADDR_W-1:0] RESET_PC = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IMM_W-1:0]  imm16_i,
  input  logic [JIDX_W-1:0] jidx_i,
  input  logic              br_eq_i,
  input  logic              br_ne_i,
  input  logic              jmp_i,
  input  logic              jreg_i,
  input  logic [ADDR_W-1:0] cmp_a_i,
  input  logic [ADDR_W-1:0] cmp_b_i,
  input  logic [ADDR_W-1:0] jreg_tgt_i,
  output logic [ADDR_W-1:0] pc_o
);
  localparam int unsigned SEXT_W   = ADDR_W - IMM_W - 2;
  localparam int unsigned REGION_W = ADDR_W - JIDX_W - 2;
  localparam logic [ADDR_W-1:0] FOUR = ADDR_W'(4);

  logic [ADDR_W-1:0] pc_q, pc_d;
  logic [ADDR_W-1:0] seq_tgt, br_tgt, jmp_tgt;
  logic              br_take;

  npc_targets #(.ADDR_W(ADDR_W), .IMM_W(IMM_W), .JIDX_W(JIDX_W)) u_targets (
    .pc_i   (pc_q),
    .imm_i  (imm16_i),
    .jidx_i (jidx_i),
    .seq_o  (seq_tgt),
    .br_o   (br_tgt),
    .jmp_o  (jmp_tgt)
  );

  npc_branch_cond #(.DATA_W(ADDR_W)) u_cond (
    .a_i     (cmp_a_i),
    .b_i     (cmp_b_i),
    .on_eq_i (br_eq_i),
    .on_ne_i (br_ne_i),
    .take_o  (br_take)
  );

  npc_select #(.ADDR_W(ADDR_W)) u_sel (
    .jreg_i    (jreg_i),
    .jmp_i     (jmp_i),
    .take_i    (br_take),
    .seq_i     (seq_tgt),
    .br_i      (br_tgt),
    .jmp_tgt_i (jmp_tgt),
    .reg_tgt_i (jreg_tgt_i),
    .next_o    (pc_d)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pc_q <= RESET_PC;
    else        pc_q <= pc_d;
  end

  assign pc_o = pc_q;

  // R2: no control raised -> sequential step
  a_r2_sequential: assert property (@(posedge clk) disable iff (!rst_n)
    (!br_eq_i && !br_ne_i && !jmp_i && !jreg_i) |=> pc_q == $past(pc_q) + FOUR);

  // R3: taken equal-branch lands on the scaled, sign-extended offset
  a_r3_beq_taken: assert property (@(posedge clk) disable iff (!rst_n)
    (br_eq_i && !br_ne_i && !jmp_i && !jreg_i && cmp_a_i == cmp_b_i) |=>
    pc_q == $past(pc_q) + FOUR +
            {{SEXT_W{$past(imm16_i[IMM_W-1])}}, $past(imm16_i), 2'b00});

  // R4: untaken equal-branch falls through
  a_r4_beq_fallthrough: assert property (@(posedge clk) disable iff (!rst_n)
    (br_eq_i && !br_ne_i && !jmp_i && !jreg_i && cmp_a_i != cmp_b_i) |=>
    pc_q == $past(pc_q) + FOUR);

  // R6: jump keeps the region of PC+4 and is word aligned
  a_r6_jump_region: assert property (@(posedge clk) disable iff (!rst_n)
    (jmp_i && !jreg_i) |=>
    (pc_q[ADDR_W-1 -: REGION_W] == $past(pc_q + FOUR) >> (ADDR_W - REGION_W)) &&
    (pc_q[1:0] == 2'b00));

  // R7, R8: register jump wins over everything and loads the value unchanged
  a_r7_jreg_load: assert property (@(posedge clk) disable iff (!rst_n)
    jreg_i |=> pc_q == $past(jreg_tgt_i));

endmodule

// File: tb/npc_unit_tb.sv
module npc_unit_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] imm16;
  logic [25:0] jidx;
  logic        beq, bne, jmp, jreg;
  logic [31:0] ca, cb, jtgt;
  logic [31:0] pc;

  int checks = 0;
  int fails  = 0;
  logic [31:0] model_pc;

  npc_unit u_dut (
    .clk(clk), .rst_n(rst_n), .imm16_i(imm16), .jidx_i(jidx),
    .br_eq_i(beq), .br_ne_i(bne), .jmp_i(jmp), .jreg_i(jreg),
    .cmp_a_i(ca), .cmp_b_i(cb), .jreg_tgt_i(jtgt), .pc_o(pc)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [31:0] br_dest(input logic [31:0] p, input logic [15:0] im);
    return p + 32'd4 + {{14{im[15]}}, im, 2'b00};
  endfunction

  function automatic logic [31:0] jmp_dest(input logic [31:0] p, input logic [25:0] ix);
    logic [31:0] nx;
    nx = p + 32'd4;
    return {nx[31:28], ix, 2'b00};
  endfunction

  task automatic check(input string req, input logic [31:0] exp);
    checks++;
    if (pc !== exp) begin
      fails++;
      $display("FAIL %s: pc=%08h expected=%08h", req, pc, exp);
    end
  endtask

  task automatic idle_inputs();
    beq = 0; bne = 0; jmp = 0; jreg = 0;
    imm16 = '0; jidx = '0; ca = '0; cb = '0; jtgt = '0;
  endtask

  // drive one cycle's controls at the falling edge, sample after the next rise
  task automatic step(input string req, input logic e, input logic n, input logic j,
                      input logic r, input logic [31:0] a, input logic [31:0] b,
                      input logic [15:0] im, input logic [25:0] ix,
                      input logic [31:0] t, input logic [31:0] exp);
    beq = e; bne = n; jmp = j; jreg = r;
    ca = a; cb = b; imm16 = im; jidx = ix; jtgt = t;
    @(posedge clk);
    @(negedge clk);
    check(req, exp);
    model_pc = exp;
    idle_inputs();
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    idle_inputs();
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 reset value", 32'h0);
    rst_n = 1'b1;
    model_pc = 32'h0;
  endtask

  task automatic t_sequential();
    step("R2 seq 1", 0,0,0,0, 0,0, 16'h0,0, 0, model_pc + 32'd4);
    step("R2 seq 2", 0,0,0,0, 0,0, 16'h1234,26'h3, 32'h55, model_pc + 32'd4);
  endtask

  task automatic t_beq();
    step("R3 R9 beq fwd", 1,0,0,0, 32'hA5A5, 32'hA5A5, 16'h0005, 0, 0,
         br_dest(model_pc, 16'h0005));
    step("R3 beq back", 1,0,0,0, 32'h0, 32'h0, 16'hFFFE, 0, 0,
         br_dest(model_pc, 16'hFFFE));
    step("R4 beq miss", 1,0,0,0, 32'h1, 32'h2, 16'h0040, 0, 0, model_pc + 32'd4);
  endtask

  task automatic t_bne();
    step("R5 bne taken", 0,1,0,0, 32'h7, 32'h8, 16'h0010, 0, 0,
         br_dest(model_pc, 16'h0010));
    step("R5 bne miss", 0,1,0,0, 32'hDEAD, 32'hDEAD, 16'h0010, 0, 0, model_pc + 32'd4);
  endtask

  task automatic t_jumps();
    step("R7 jreg", 0,0,0,1, 0,0, 0,0, 32'h0FFF_FFFC, 32'h0FFF_FFFC);
    step("R10 jump crosses region", 0,0,1,0, 0,0, 0, 26'h0000123, 0,
         jmp_dest(model_pc, 26'h0000123));
    step("R6 jump", 0,0,1,0, 0,0, 0, 26'h3FF_FFFF, 0, 32'h1FFF_FFFC);
    step("R7 jreg unaligned", 0,0,0,1, 0,0, 0,0, 32'h8000_0002, 32'h8000_0002);
  endtask

  task automatic t_priority();
    step("R8 jreg over jump", 1,0,1,1, 32'h3, 32'h3, 16'h0100, 26'h5, 32'h0000_4000,
         32'h0000_4000);
    step("R8 jump over branch", 1,0,1,0, 32'h3, 32'h3, 16'h0100, 26'h5, 0,
         jmp_dest(model_pc, 26'h5));
    step("R9 seq after redirect", 0,0,0,0, 0,0, 0,0, 0, model_pc + 32'd4);
  endtask

  task automatic t_wrap();
    step("R7 jreg top", 0,0,0,1, 0,0, 0,0, 32'hFFFF_FFFC, 32'hFFFF_FFFC);
    step("R10 wrap", 0,0,0,0, 0,0, 0,0, 0, 32'h0);
    step("R10 branch wrap back", 1,0,0,0, 32'h0, 32'h0, 16'hFFFE, 0, 0, 32'hFFFF_FFFC);
  endtask

  task automatic t_reset_midrun();
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check("R1 async reset midrun", 32'h0);
    @(negedge clk);
    check("R1 held in reset", 32'h0);
    rst_n = 1'b1;
    model_pc = 32'h0;
    step("R1 R2 first after reset", 0,0,0,0, 0,0, 0,0, 0, 32'h4);
  endtask

  initial begin
    t_reset();
    t_sequential();
    t_beq();
    t_bne();
    t_jumps();
    t_priority();
    t_wrap();
    t_reset_midrun();
    $display("  %0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    checks++;
    fails++;
    $display("FAIL watchdog: pc=%08h expected=run completion", pc);
    $display("  %0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule